// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns the address operands of one memory reference into an operand offset and a linear address. A request carries the base and index register values with their register identifiers, a two-bit scale code, a displacement that has already been sign-extended to 32 bits, a 16-bit segment selector and a 32-bit descriptor base. It also carries three mode bits: real or protected operation, the default-size bit taken from the code descriptor, and a per-instruction size override. From these the block picks 16-bit or 32-bit addressing, checks that the chosen registers are legal for that width, sums the terms, and adds the segment contribution.

Requests enter through a valid/ready pair, and only one request is in flight at a time. The result appears on the outputs for exactly one cycle, marked by `resValid`. When both a base and an index are present, the two register terms are merged in an extra cycle, so that result arrives one cycle later than for the other combinations. An illegal register choice gives an error response with no address. In real mode, an offset beyond 64 KiB gives a general-protection fault.

Top module: `segEaGen`

## Requirements
- R1: The width is chosen as follows. In protected mode (`protMode`=1), 32-bit addressing is used when `descWide` XOR `sizeFlip` is 1, and 16-bit addressing otherwise. In real mode, 32-bit addressing is used only when `sizeFlip`=1.
- R2: In 32-bit addressing, `offset` = base + (index << `scaleCode`) + `dispVal`, modulo 2^32. Scale codes 0, 1, 2 and 3 mean factors of 1, 2, 4 and 8. A term whose use flag is 0 counts as zero.
- R3: In 16-bit addressing, the low 16 bits of base, index and displacement are summed modulo 2^16. `scaleCode` has no effect, and `offset[31:16]` is 0.
- R4: In 16-bit addressing, the only legal base identifiers are 3 and 5, and the only legal index identifiers are 6 and 7. Any other identifier on a used term gives a response with `regError`=1, `offset`=0, `linAddr`=0 and `gpFault`=0.
- R5: In 32-bit addressing, index identifier 4 (the stack pointer) is illegal and gives the error response of R4. Any identifier is legal as a base.
- R6: In real mode, `linAddr` = (`segSel` << 4) + `offset`, with the selector zero-extended.
- R7: In protected mode, `linAddr` = `segBase` + `offset`, modulo 2^32.
- R8: In real mode, an `offset` above 0xFFFF (possible only under 32-bit addressing) gives `gpFault`=1 and `linAddr`=0. Protected mode never faults.
- R9: `resValid` rises in the cycle after acceptance. It rises one cycle later still when both base and index are used and the request is legal.
- R10: A request is accepted at a clock edge where `reqValid` and `reqReady` are both 1. `reqReady` is 0 from acceptance until `resValid` has been shown, and `resValid` lasts exactly one cycle.
- R11: After reset, `reqReady`=1 and `resValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to accept a request |
| protMode | input | 1 | 1 = protected mode, 0 = real mode |
| descWide | input | 1 | Default-size bit from the code descriptor |
| sizeFlip | input | 1 | Per-instruction address-size override |
| baseUsed | input | 1 | Base term present |
| baseSel | input | 3 | Base register identifier |
| baseVal | input | 32 | Base register value |
| indexUsed | input | 1 | Index term present |
| indexSel | input | 3 | Index register identifier |
| indexVal | input | 32 | Index register value |
| scaleCode | input | 2 | Index scale, log2 of the factor |
| dispVal | input | 32 | Sign-extended displacement |
| segSel | input | 16 | Segment selector (real mode) |
| segBase | input | 32 | Descriptor base address (protected mode) |
| resValid | output | 1 | One-cycle result strobe |
| offset | output | 32 | Effective offset |
| linAddr | output | 32 | Linear address |
| gpFault | output | 1 | Real-mode offset exceeds 64 KiB |
| regError | output | 1 | Illegal register for the active width |

## Verification
The bench targets the width decision in all four combinations of mode and override, and the 16-bit wrap, where a design that kept the carry would leak a bit into `offset[16]` and displace the linear address. It uses the stack-pointer identifier both as an index and as a base: a design that mixed up the two checks would either let a bad index through or reject a good base. It also probes the real-mode bound at exactly 0xFFFF and at 0x10000, and protected-base wraparound. Latency is checked against the cycle of acceptance, so a design that always took the extra cycle, or skipped it for base-plus-index, shows up as a timing mismatch rather than a data mismatch.

// File: rtl/segea_pkg.sv
package segea_pkg;

  localparam int REG_ID_W = 3;

  // Register identifiers whose legality depends on the addressing width
  localparam logic [REG_ID_W-1:0] ID_BASE_A = 3'd3;
  localparam logic [REG_ID_W-1:0] ID_STACK  = 3'd4;
  localparam logic [REG_ID_W-1:0] ID_BASE_B = 3'd5;
  localparam logic [REG_ID_W-1:0] ID_IDX_A  = 3'd6;
  localparam logic [REG_ID_W-1:0] ID_IDX_B  = 3'd7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MERGE = 2'd1,
    ST_EMIT  = 2'd2
  } eaState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch request operands
    logic merge;    // fold scaled index into accumulator
    logic emit;     // result presented this cycle
  } eaStrobe_t;

endpackage

// File: rtl/segea_ctrl.sv
module segea_ctrl
  import segea_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      baseUsed,
  input  logic      indexUsed,
  input  logic      reqIllegal,
  output logic      reqReady,
  output eaStrobe_t strobe
);

  eaState_t state, stateNext;
  logic accept;
  logic twoStep;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign twoStep  = baseUsed && indexUsed && !reqIllegal;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (accept) stateNext = twoStep ? ST_MERGE : ST_EMIT;
      ST_MERGE: stateNext = ST_EMIT;
      ST_EMIT:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.capture = accept;
    strobe.merge   = (state == ST_MERGE);
    strobe.emit    = (state == ST_EMIT);
  end

  // R9: single-term or erroneous requests answer on the next cycle
  a_r9_single_latency: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !twoStep) |=> strobe.emit);

  // R9: base plus index takes one more cycle
  a_r9_merge_latency: assert property (@(posedge clk) disable iff (!rstN)
    (accept && twoStep) |=> (!strobe.emit ##1 strobe.emit));

  // R10: no acceptance while a result is shown
  a_r10_busy_while_emit: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |-> !reqReady);

  // R10: result strobe is a single cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |=> !strobe.emit);

endmodule

// File: rtl/segea_datapath.sv
module segea_datapath
  import segea_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SEG_W     = 16,
  parameter int NARROW_W  = 16,
  parameter int SEG_SHIFT = 4,
  parameter int SCALE_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  eaStrobe_t           strobe,
  input  logic                protMode,
  input  logic                descWide,
  input  logic                sizeFlip,
  input  logic                baseUsed,
  input  logic [REG_ID_W-1:0] baseSel,
  input  logic [ADDR_W-1:0]   baseVal,
  input  logic                indexUsed,
  input  logic [REG_ID_W-1:0] indexSel,
  input  logic [ADDR_W-1:0]   indexVal,
  input  logic [SCALE_W-1:0]  scaleCode,
  input  logic [ADDR_W-1:0]   dispVal,
  input  logic [SEG_W-1:0]    segSel,
  input  logic [ADDR_W-1:0]   segBase,
  output logic                reqIllegal,
  output logic [ADDR_W-1:0]   offset,
  output logic [ADDR_W-1:0]   linAddr,
  output logic                gpFault,
  output logic                regError
);

  localparam int PAD_NARROW = ADDR_W - NARROW_W;
  localparam int PAD_SEG    = ADDR_W - SEG_W - SEG_SHIFT;

  // ---------------- request decode ----------------
  logic wantWide;
  logic baseOkNarrow, idxOkNarrow;
  logic [ADDR_W-1:0] baseTerm, idxTerm, dispTerm, segTerm;

  assign wantWide     = protMode ? (descWide ^ sizeFlip) : sizeFlip;
  assign baseOkNarrow = (baseSel == ID_BASE_A) || (baseSel == ID_BASE_B);
  assign idxOkNarrow  = (indexSel == ID_IDX_A) || (indexSel == ID_IDX_B);

  always_comb begin
    if (wantWide) reqIllegal = indexUsed && (indexSel == ID_STACK);
    else          reqIllegal = (baseUsed && !baseOkNarrow) || (indexUsed && !idxOkNarrow);
  end

  always_comb begin
    baseTerm = '0;
    idxTerm  = '0;
    if (baseUsed)
      baseTerm = wantWide ? baseVal : {{PAD_NARROW{1'b0}}, baseVal[NARROW_W-1:0]};
    if (indexUsed)
      idxTerm  = wantWide ? (indexVal << scaleCode)
                          : {{PAD_NARROW{1'b0}}, indexVal[NARROW_W-1:0]};
    dispTerm = wantWide ? dispVal : {{PAD_NARROW{1'b0}}, dispVal[NARROW_W-1:0]};
    segTerm  = protMode ? segBase : {{PAD_SEG{1'b0}}, segSel, {SEG_SHIFT{1'b0}}};
  end

  // ---------------- operand registers ----------------
  logic [ADDR_W-1:0] accQ, idxQ, dispQ, segQ;
  logic wideQ, protQ, errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ  <= '0;
      idxQ  <= '0;
      dispQ <= '0;
      segQ  <= '0;
      wideQ <= 1'b0;
      protQ <= 1'b0;
      errQ  <= 1'b0;
    end else if (strobe.capture) begin
      // with a single register term only one of the two is nonzero
      accQ  <= (baseUsed && indexUsed) ? baseTerm : (baseTerm | idxTerm);
      idxQ  <= idxTerm;
      dispQ <= dispTerm;
      segQ  <= segTerm;
      wideQ <= wantWide;
      protQ <= protMode;
      errQ  <= reqIllegal;
    end else if (strobe.merge) begin
      accQ  <= accQ + idxQ;
    end
  end

  // ---------------- result formation ----------------
  logic [ADDR_W-1:0] sumFull, offsetNow, linRaw;
  logic overReal;

  always_comb begin
    sumFull   = accQ + dispQ;
    offsetNow = wideQ ? sumFull : {{PAD_NARROW{1'b0}}, sumFull[NARROW_W-1:0]};
    overReal  = !protQ && (|offsetNow[ADDR_W-1:NARROW_W]);
    linRaw    = segQ + offsetNow;
    regError  = errQ;
    gpFault   = !errQ && overReal;
    offset    = errQ ? '0 : offsetNow;
    linAddr   = (errQ || overReal) ? '0 : linRaw;
  end

  // R3: narrow results never carry above the low half
  a_r3_narrow_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && !wideQ) |-> (offset[ADDR_W-1:NARROW_W] == '0));

  // R8: faults only in real mode and never with an address
  a_r8_fault_real_only: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && gpFault) |-> (!protQ && linAddr == '0));

  // R4: an error response carries no address and no fault
  a_r4_error_empty: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && regError) |-> (!gpFault && offset == '0 && linAddr == '0));

endmodule

// File: rtl/segEaGen.sv
module segEaGen
  import segea_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SEG_W     = 16,
  parameter int NARROW_W  = 16,
  parameter int SEG_SHIFT = 4,
  parameter int SCALE_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                protMode,
  input  logic                descWide,
  input  logic                sizeFlip,
  input  logic                baseUsed,
  input  logic [REG_ID_W-1:0] baseSel,
  input  logic [ADDR_W-1:0]   baseVal,
  input  logic                indexUsed,
  input  logic [REG_ID_W-1:0] indexSel,
  input  logic [ADDR_W-1:0]   indexVal,
  input  logic [SCALE_W-1:0]  scaleCode,
  input  logic [ADDR_W-1:0]   dispVal,
  input  logic [SEG_W-1:0]    segSel,
  input  logic [ADDR_W-1:0]   segBase,
  output logic                resValid,
  output logic [ADDR_W-1:0]   offset,
  output logic [ADDR_W-1:0]   linAddr,
  output logic                gpFault,
  output logic                regError
);

  eaStrobe_t strobe;
  logic reqIllegal;

  segea_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .baseUsed   (baseUsed),
    .indexUsed  (indexUsed),
    .reqIllegal (reqIllegal),
    .reqReady   (reqReady),
    .strobe     (strobe)
  );

  segea_datapath #(
    .ADDR_W    (ADDR_W),
    .SEG_W     (SEG_W),
    .NARROW_W  (NARROW_W),
    .SEG_SHIFT (SEG_SHIFT),
    .SCALE_W   (SCALE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .protMode   (protMode),
    .descWide   (descWide),
    .sizeFlip   (sizeFlip),
    .baseUsed   (baseUsed),
    .baseSel    (baseSel),
    .baseVal    (baseVal),
    .indexUsed  (indexUsed),
    .indexSel   (indexSel),
    .indexVal   (indexVal),
    .scaleCode  (scaleCode),
    .dispVal    (dispVal),
    .segSel     (segSel),
    .segBase    (segBase),
    .reqIllegal (reqIllegal),
    .offset     (offset),
    .linAddr    (linAddr),
    .gpFault    (gpFault),
    .regError   (regError)
  );

  assign resValid = strobe.emit;

endmodule

// File: tb/segEaGen_test.sv
module segEaGen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        protMode = 1'b0, descWide = 1'b0, sizeFlip = 1'b0;
  logic        baseUsed = 1'b0, indexUsed = 1'b0;
  logic [2:0]  baseSel = '0, indexSel = '0;
  logic [31:0] baseVal = '0, indexVal = '0, dispVal = '0, segBase = '0;
  logic [1:0]  scaleCode = '0;
  logic [15:0] segSel = '0;
  logic        resValid;
  logic [31:0] offset, linAddr;
  logic        gpFault, regError;

  segEaGen uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .protMode(protMode), .descWide(descWide), .sizeFlip(sizeFlip),
    .baseUsed(baseUsed), .baseSel(baseSel), .baseVal(baseVal),
    .indexUsed(indexUsed), .indexSel(indexSel), .indexVal(indexVal),
    .scaleCode(scaleCode), .dispVal(dispVal), .segSel(segSel), .segBase(segBase),
    .resValid(resValid), .offset(offset), .linAddr(linAddr),
    .gpFault(gpFault), .regError(regError)
  );

  always #10 clk = ~clk;  // 50 MHz

  int applied = 0;
  int misses  = 0;
  int cyc     = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [31:0] off;
    logic [31:0] lin;
    logic        gp;
    logic        err;
    int          due;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  function automatic expItem_t model(
    input logic prot, input logic dw, input logic ov,
    input logic bu, input logic [2:0] bs, input logic [31:0] bv,
    input logic iu, input logic [2:0] is, input logic [31:0] iv,
    input logic [1:0] sc, input logic [31:0] dv,
    input logic [15:0] sel, input logic [31:0] sb);
    expItem_t e;
    logic wide;
    logic [15:0] s16;
    wide  = prot ? (dw ^ ov) : ov;                 // R1
    e.err = wide ? (iu && is == 3'd4)              // R5
                 : ((bu && !(bs == 3'd3 || bs == 3'd5)) ||
                    (iu && !(is == 3'd6 || is == 3'd7)));  // R4
    if (bu && iu && !e.err) e.due = 2; else e.due = 1;     // R9
    e.gp = 1'b0; e.off = '0; e.lin = '0;
    if (!e.err) begin
      if (wide)
        e.off = (bu ? bv : 32'd0) + (iu ? (iv * (32'd1 << sc)) : 32'd0) + dv;  // R2
      else begin
        s16 = (bu ? bv[15:0] : 16'd0) + (iu ? iv[15:0] : 16'd0) + dv[15:0];  // R3
        e.off = {16'd0, s16};
      end
      e.gp = !prot && (e.off > 32'h0000_FFFF);      // R8
      if (e.gp)      e.lin = '0;
      else if (prot) e.lin = sb + e.off;            // R7
      else           e.lin = {12'd0, sel, 4'd0} + e.off;  // R6
    end
    return e;
  endfunction

  task automatic apply(
    input string tag,
    input logic prot, input logic dw, input logic ov,
    input logic bu, input logic [2:0] bs, input logic [31:0] bv,
    input logic iu, input logic [2:0] is, input logic [31:0] iv,
    input logic [1:0] sc, input logic [31:0] dv,
    input logic [15:0] sel, input logic [31:0] sb);
    expItem_t e;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    e = model(prot, dw, ov, bu, bs, bv, iu, is, iv, sc, dv, sel, sb);
    e.due = cyc + e.due;
    e.tag = tag;
    expQ.push_back(e);
    protMode = prot; descWide = dw; sizeFlip = ov;
    baseUsed = bu; baseSel = bs; baseVal = bv;
    indexUsed = iu; indexSel = is; indexVal = iv;
    scaleCode = sc; dispVal = dv; segSel = sel; segBase = sb;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    applied++;
    if (reqReady !== 1'b0) begin  // R10: busy after acceptance
      misses++;
      $display("FAIL R10 reqReady after accept: actual %b expected 0", reqReady);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && resValid && !finished) begin
      applied++;
      if (expQ.size() == 0) begin
        misses++;
        $display("FAIL R10 unexpected resValid: actual 1 expected 0");
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (offset !== e.off || linAddr !== e.lin || gpFault !== e.gp ||
            regError !== e.err || cyc != e.due) begin
          misses++;
          $display("FAIL %s: actual off=%h lin=%h gp=%b err=%b cyc=%0d expected off=%h lin=%h gp=%b err=%b cyc=%0d",
                   e.tag, offset, linAddr, gpFault, regError, cyc,
                   e.off, e.lin, e.gp, e.err, e.due);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    applied++;
    if (reqReady !== 1'b1 || resValid !== 1'b0) begin  // R11
      misses++;
      $display("FAIL R11 reset: actual ready=%b valid=%b expected ready=1 valid=0",
               reqReady, resValid);
    end

    // tag, prot, D, ovr, bu, bs, bv, iu, is, iv, sc, disp, sel, segBase
    apply("R2 base+disp", 1, 1, 0, 1, 3'd0, 32'h0000_1000, 0, 3'd0, 32'h0, 2'd0,
          32'h0000_0024, 16'h0, 32'h0040_0000);
    apply("R2 scaled index", 1, 1, 0, 0, 3'd0, 32'h0, 1, 3'd1, 32'h0000_0010, 2'd3,
          32'hFFFF_FFFC, 16'h0, 32'h0000_0000);
    apply("R9 base+index wide", 1, 1, 0, 1, 3'd2, 32'h1000_0000, 1, 3'd6, 32'h0000_0100, 2'd2,
          32'h0000_0008, 16'h0, 32'h0001_0000);
    apply("R5 stack index", 1, 1, 0, 1, 3'd0, 32'h5, 1, 3'd4, 32'h9, 2'd0,
          32'h0, 16'h0, 32'h0);
    apply("R5 stack base", 1, 1, 0, 1, 3'd4, 32'h0000_8000, 0, 3'd0, 32'h0, 2'd0,
          32'h0000_0010, 16'h0, 32'h0000_0100);
    apply("R3 narrow wrap", 0, 0, 0, 1, 3'd3, 32'hABCD_1234, 1, 3'd6, 32'h0000_F000, 2'd3,
          32'hFFFF_FFF0, 16'h1234, 32'h0);
    apply("R4 narrow base id", 0, 0, 0, 1, 3'd0, 32'h10, 0, 3'd0, 32'h0, 2'd0,
          32'h0, 16'h0100, 32'h0);
    apply("R4 narrow index id", 0, 0, 0, 0, 3'd0, 32'h0, 1, 3'd5, 32'h20, 2'd0,
          32'h0, 16'h0100, 32'h0);
    apply("R6 real at bound", 0, 0, 1, 1, 3'd1, 32'h0000_FFFF, 0, 3'd0, 32'h0, 2'd0,
          32'h0, 16'hFFFF, 32'h0);
    apply("R8 real over bound", 0, 0, 1, 1, 3'd1, 32'h0000_FFFF, 0, 3'd0, 32'h0, 2'd0,
          32'h0000_0001, 16'h0010, 32'h0);
    apply("R1 prot D1 override", 1, 1, 1, 1, 3'd5, 32'h0001_FFFF, 0, 3'd0, 32'h0, 2'd0,
          32'h0000_0002, 16'h0, 32'h2000_0000);
    apply("R1 prot D0 plain", 1, 0, 0, 0, 3'd0, 32'h0, 1, 3'd7, 32'h0003_8000, 2'd1,
          32'h0, 16'h0, 32'h0000_4000);
    apply("R1 prot D0 override", 1, 0, 1, 0, 3'd0, 32'h0, 1, 3'd7, 32'h0003_8000, 2'd1,
          32'h0, 16'h0, 32'h0000_4000);
    apply("R7 base wrap", 1, 1, 0, 1, 3'd1, 32'h0000_2000, 0, 3'd0, 32'h0, 2'd0,
          32'h0, 16'h0, 32'hFFFF_F000);
    apply("R2 disp only", 1, 1, 0, 0, 3'd0, 32'h0, 0, 3'd0, 32'h0, 2'd3,
          32'h8000_0000, 16'h0, 32'h0000_0010);
    apply("R6 real narrow both", 0, 0, 0, 1, 3'd5, 32'h0000_0200, 1, 3'd7, 32'h0000_0030, 2'd0,
          32'h0000_0004, 16'hB800, 32'h0);

    for (int k = 0; k < 80; k++) begin
      logic [31:0] r1, r2, r3, r4;
      r1 = $urandom; r2 = $urandom; r3 = $urandom; r4 = $urandom;
      apply("R2 R3 R6 R7 random", r4[0], r4[1], r4[2], r4[3], r4[6:4], r1,
            r4[7], r4[10:8], r2 >> r4[13:11], r4[15:14], {{24{r3[7]}}, r3[7:0]} ^ (r4[16] ? r3 : 32'h0),
            r3[31:16], r1 ^ r2);
    end

    repeat (4) @(negedge clk);
    applied++;
    if (expQ.size() != 0) begin
      misses++;
      $display("FAIL R9 missing results: actual %0d pending expected 0", expQ.size());
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
    $finish;
  end

endmodule